// File: doc/BRIEF.md
# Way-Limited LRU Victim Selector

This block chooses the way to replace in one set of an N-way set-associative cache. Only the lowest k physical ways may receive new lines. For each set it keeps a recency stack: each stack position holds a physical way number. Position 0 is the most recently used way and position N-1 is the least recently used way. A hit or a fill to a way moves that way to the front of its set's stack.

To find a victim, the block first looks for an invalid way below the limit. If there is none, it walks the stack from the least recent position toward the most recent one and takes the first way whose number is below k. Software can program the limit k. A write of a value outside 1..N is refused, and the refusal raises a one-cycle error flag.

The recency state can be read directly by giving a (set, way) pair. The block then returns the stack position of that way, with no tag involved. The result of each selection is registered and appears one cycle after the request.

Top module: `lru_way_limit`

## Requirements
- R1: After reset the limit equals N. In every set, stack position i holds physical way i, so a probe of way i returns position i. The outputs selDone, victimValid and limitErr are low.
- R2: A limit write with a value in 1..N is accepted, and limitCur shows the new value from the next cycle onward.
- R3: A limit write with value 0 or a value above N is refused. limitCur keeps its old value, and limitErr is high for exactly the one cycle after the write.
- R4: A touch of (set, way) moves that way to position 0 of that set. Every entry that sat at a position above it shifts one position toward the least recent end. Entries at higher positions keep their places.
- R5: When every way below k is valid, the victim is the way found first when the stack is walked from position N-1 toward position 0 and a way number below k is required.
- R6: When one or more ways below k are invalid (validBits bit w low for way w), the victim is the lowest-numbered such way. Invalid ways at or above k are not chosen.
- R7: A reported victim always has a way number below the limit that was in force when the selection was made.
- R8: selDone and the victim outputs are registered. They reflect a request one cycle after selReq is high, and selDone is low in any cycle that follows a cycle without a request.
- R9: victimValid is high together with selDone whenever the search finds an eligible way. Because k is never below 1, every completed selection reports a victim.
- R10: A probe of (set, way) returns that way's stack position one cycle later. A touch in one set leaves every other set's stack unchanged.
- R11: A selection and a touch in the same cycle on the same set are resolved on the stack as it was before the touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selReq | input | 1 | Request a victim search in lookupSet |
| lookupSet | input | SET_W | Set to search |
| validBits | input | NUM_WAYS | Valid bit per way of lookupSet (bit w = way w) |
| limitWr | input | 1 | Write strobe for the allocation limit |
| limitIn | input | LIM_W | New limit value |
| touchEn | input | 1 | Hit or fill update strobe |
| touchSet | input | SET_W | Set being updated |
| touchWay | input | WAY_W | Way made most recent |
| probeSet | input | SET_W | Set of the direct recency probe |
| probeWay | input | WAY_W | Way of the direct recency probe |
| selDone | output | 1 | A search result is present |
| victimValid | output | 1 | The search found an eligible way |
| victimWay | output | WAY_W | Chosen victim way |
| limitCur | output | LIM_W | Current allocation limit |
| limitErr | output | 1 | The previous limit write was refused |
| probePos | output | WAY_W | Stack position of the probed way |

## Verification
The hardest situation to create from the ports is a stack in which recency order and way numbering disagree. Only such a stack shows whether the walk skips high-numbered least-recent ways rather than simply picking the highest way number below k. The stimulus touches one set in a scrambled order, so its least-recent-to-most-recent order becomes 2, 0, 3, 1. It then sweeps the limit and the valid pattern over a vector table while a second set stays in reset order. The same-cycle touch and select case is built by asserting both strobes on one set in a single cycle and then selecting again.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef struct packed {
    logic selGo;
    logic touchGo;
  } lruStrobes_t;
endpackage

// File: rtl/lru_ctrl.sv
module lru_ctrl #(
  parameter int NUM_WAYS = 4,
  localparam int LIM_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 selReq,
  input  logic                 touchEn,
  input  logic                 limitWr,
  input  logic [LIM_W-1:0]     limitIn,
  output lru_pkg::lruStrobes_t strobes,
  output logic [LIM_W-1:0]     limitQ,
  output logic                 limitErrQ
);
  logic limitBad;

  assign limitBad = (limitIn == '0) || (limitIn > LIM_W'(NUM_WAYS));

  always_comb begin
    strobes.selGo   = selReq;
    strobes.touchGo = touchEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limitQ    <= LIM_W'(NUM_WAYS);
      limitErrQ <= 1'b0;
    end else begin
      limitErrQ <= limitWr && limitBad;
      if (limitWr && !limitBad) limitQ <= limitIn;
    end
  end

  // R3: the limit stays inside 1..N at all times
  a_r3_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (limitQ >= LIM_W'(1)) && (limitQ <= LIM_W'(NUM_WAYS)));

  // R3: a refused write leaves the limit untouched
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    limitErrQ |-> $stable(limitQ));

  // R2: an accepted write shows up one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (limitWr && !limitBad) |=> (limitQ == $past(limitIn)));
endmodule

// File: rtl/lru_datapath.sv
module lru_datapath #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int LIM_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lru_pkg::lruStrobes_t strobes,
  input  logic [LIM_W-1:0]     limit,
  input  logic [SET_W-1:0]     lookupSet,
  input  logic [NUM_WAYS-1:0]  validBits,
  input  logic [SET_W-1:0]     touchSet,
  input  logic [WAY_W-1:0]     touchWay,
  input  logic [SET_W-1:0]     probeSet,
  input  logic [WAY_W-1:0]     probeWay,
  output logic                 selDone,
  output logic                 victimValid,
  output logic [WAY_W-1:0]     victimWay,
  output logic [WAY_W-1:0]     probePos
);
  logic [WAY_W-1:0] stackQ [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] rowNext [NUM_WAYS];
  logic [WAY_W-1:0] oldPos;
  logic [WAY_W-1:0] lruWay, invWay, probePosD;
  logic             lruFound, invFound;

  // move-to-front of the touched way
  always_comb begin
    oldPos = '0;
    for (int p = 0; p < NUM_WAYS; p++)
      if (stackQ[touchSet][p] == touchWay) oldPos = WAY_W'(p);
    rowNext[0] = touchWay;
    for (int i = 1; i < NUM_WAYS; i++)
      rowNext[i] = (WAY_W'(i) <= oldPos) ? stackQ[touchSet][i-1] : stackQ[touchSet][i];
  end

  // victim search: invalid eligible way first, then least recent eligible way
  always_comb begin
    invFound = 1'b0;
    invWay   = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (!invFound && !validBits[w] && (LIM_W'(w) < limit)) begin
        invFound = 1'b1;
        invWay   = WAY_W'(w);
      end
    lruFound = 1'b0;
    lruWay   = '0;
    for (int p = NUM_WAYS - 1; p >= 0; p--)
      if (!lruFound && (LIM_W'(stackQ[lookupSet][p]) < limit)) begin
        lruFound = 1'b1;
        lruWay   = stackQ[lookupSet][p];
      end
  end

  always_comb begin
    probePosD = '0;
    for (int p = 0; p < NUM_WAYS; p++)
      if (stackQ[probeSet][p] == probeWay) probePosD = WAY_W'(p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int p = 0; p < NUM_WAYS; p++)
          stackQ[s][p] <= WAY_W'(p);
      selDone     <= 1'b0;
      victimValid <= 1'b0;
      victimWay   <= '0;
      probePos    <= '0;
    end else begin
      if (strobes.touchGo)
        for (int i = 0; i < NUM_WAYS; i++)
          stackQ[touchSet][i] <= rowNext[i];
      selDone     <= strobes.selGo;
      victimValid <= strobes.selGo && (invFound || lruFound);
      victimWay   <= invFound ? invWay : lruWay;
      probePos    <= probePosD;
    end
  end

  // R7: victim is below the limit that held when the search ran
  a_r7_victim_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> (LIM_W'(victimWay) < $past(limit)));

  // R8: result timing follows the request by one cycle
  a_r8_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.selGo |=> selDone);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.selGo |=> !selDone);

  // R9: with a legal limit every selection yields a victim
  a_r9_always_victim: assert property (@(posedge clk) disable iff (!rst_n)
    selDone |-> victimValid);

  // R4: the touched way lands at the front of its set
  a_r4_touch_to_front: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.touchGo |=> (stackQ[$past(touchSet)][0] == $past(touchWay)));
endmodule

// File: rtl/lru_way_limit.sv
module lru_way_limit #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int LIM_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                selReq,
  input  logic [SET_W-1:0]    lookupSet,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic                limitWr,
  input  logic [LIM_W-1:0]    limitIn,
  input  logic                touchEn,
  input  logic [SET_W-1:0]    touchSet,
  input  logic [WAY_W-1:0]    touchWay,
  input  logic [SET_W-1:0]    probeSet,
  input  logic [WAY_W-1:0]    probeWay,
  output logic                selDone,
  output logic                victimValid,
  output logic [WAY_W-1:0]    victimWay,
  output logic [LIM_W-1:0]    limitCur,
  output logic                limitErr,
  output logic [WAY_W-1:0]    probePos
);
  lru_pkg::lruStrobes_t strobes;

  lru_ctrl #(.NUM_WAYS(NUM_WAYS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .selReq(selReq), .touchEn(touchEn),
    .limitWr(limitWr), .limitIn(limitIn), .strobes(strobes),
    .limitQ(limitCur), .limitErrQ(limitErr)
  );

  lru_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .limit(limitCur),
    .lookupSet(lookupSet), .validBits(validBits),
    .touchSet(touchSet), .touchWay(touchWay),
    .probeSet(probeSet), .probeWay(probeWay),
    .selDone(selDone), .victimValid(victimValid), .victimWay(victimWay),
    .probePos(probePos)
  );
endmodule

// File: tb/test_lru_way_limit.sv
module test_lru_way_limit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       selReq = 1'b0;
  logic [1:0] lookupSet = '0;
  logic [3:0] validBits = '0;
  logic       limitWr = 1'b0;
  logic [2:0] limitIn = '0;
  logic       touchEn = 1'b0;
  logic [1:0] touchSet = '0;
  logic [1:0] touchWay = '0;
  logic [1:0] probeSet = '0;
  logic [1:0] probeWay = '0;
  logic       selDone, victimValid, limitErr;
  logic [1:0] victimWay, probePos;
  logic [2:0] limitCur;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lru_way_limit i_lru_way_limit (
    .clk(clk), .rst_n(rst_n), .selReq(selReq), .lookupSet(lookupSet),
    .validBits(validBits), .limitWr(limitWr), .limitIn(limitIn),
    .touchEn(touchEn), .touchSet(touchSet), .touchWay(touchWay),
    .probeSet(probeSet), .probeWay(probeWay), .selDone(selDone),
    .victimValid(victimValid), .victimWay(victimWay), .limitCur(limitCur),
    .limitErr(limitErr), .probePos(probePos)
  );

  // {set, validBits, k, expected victim}; set 1 LRU->MRU order is 2,0,3,1
  localparam logic [10:0] VEC [11] = '{
    {2'd1, 4'b1111, 3'd4, 2'd2},
    {2'd1, 4'b1111, 3'd2, 2'd0},
    {2'd1, 4'b1111, 3'd1, 2'd0},
    {2'd1, 4'b1111, 3'd3, 2'd2},
    {2'd1, 4'b1110, 3'd4, 2'd0},
    {2'd1, 4'b0111, 3'd3, 2'd2},
    {2'd1, 4'b0111, 3'd4, 2'd3},
    {2'd1, 4'b1101, 3'd1, 2'd0},
    {2'd0, 4'b1111, 3'd4, 2'd3},
    {2'd0, 4'b1111, 3'd3, 2'd2},
    {2'd0, 4'b1111, 3'd2, 2'd1}
  };

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeLimit(int k);
    @(negedge clk); limitWr = 1'b1; limitIn = 3'(k);
    @(negedge clk); limitWr = 1'b0;
  endtask

  task automatic touch(int s, int w);
    @(negedge clk); touchEn = 1'b1; touchSet = 2'(s); touchWay = 2'(w);
    @(negedge clk); touchEn = 1'b0;
  endtask

  task automatic select(int s, logic [3:0] v);
    @(negedge clk); selReq = 1'b1; lookupSet = 2'(s); validBits = v;
    @(negedge clk); selReq = 1'b0;
  endtask

  task automatic probe(int s, int w);
    @(negedge clk); probeSet = 2'(s); probeWay = 2'(w);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 limit", int'(limitCur), 4);
    check("R1 selDone", int'(selDone), 0);
    check("R1 victimValid", int'(victimValid), 0);
    check("R1 limitErr", int'(limitErr), 0);
    for (int w = 0; w < 4; w++) begin
      probe(2, w);
      check("R1 stack order", int'(probePos), w);
    end

    // R3 refused writes
    writeLimit(0);
    check("R3 err on zero", int'(limitErr), 1);
    check("R3 keep on zero", int'(limitCur), 4);
    @(negedge clk);
    check("R3 err one cycle", int'(limitErr), 0);
    writeLimit(5);
    check("R3 err above N", int'(limitErr), 1);
    check("R3 keep above N", int'(limitCur), 4);

    // R2 accepted write
    writeLimit(2);
    check("R2 limit accepted", int'(limitCur), 2);
    check("R2 no err", int'(limitErr), 0);

    // R4 scramble set 1
    touch(1, 2); touch(1, 0); touch(1, 3); touch(1, 1);
    probe(1, 1); check("R4 pos way1", int'(probePos), 0);
    probe(1, 3); check("R4 pos way3", int'(probePos), 1);
    probe(1, 0); check("R4 pos way0", int'(probePos), 2);
    probe(1, 2); check("R4 pos way2", int'(probePos), 3);
    // R10 other set untouched
    probe(0, 3); check("R10 set0 way3", int'(probePos), 3);
    probe(0, 0); check("R10 set0 way0", int'(probePos), 0);

    // R5 R6 R7 R9 table walk
    for (int i = 0; i < 11; i++) begin
      writeLimit(int'(VEC[i][4:2]));
      select(int'(VEC[i][10:9]), VEC[i][8:5]);
      check("R9 victimValid", int'(victimValid), 1);
      check("R5/R6 victim", int'(victimWay), int'(VEC[i][1:0]));
      check("R7 below limit", int'(victimWay < 2'(VEC[i][4:2]) || VEC[i][4:2] == 3'd4), 1);
    end

    // R8 no request -> no done
    @(negedge clk);
    check("R8 idle done", int'(selDone), 0);

    // R11 same-cycle touch and select on set 0 (order 0,1,2,3), k=4
    writeLimit(4);
    @(negedge clk);
    selReq = 1'b1; lookupSet = 2'd0; validBits = 4'b1111;
    touchEn = 1'b1; touchSet = 2'd0; touchWay = 2'd3;
    @(negedge clk);
    selReq = 1'b0; touchEn = 1'b0;
    check("R11 pre-touch victim", int'(victimWay), 3);
    check("R8 done after req", int'(selDone), 1);
    select(0, 4'b1111);
    check("R11 post-touch victim", int'(victimWay), 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule